// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Debug Freeze

This block holds the two sample queues of a serial audio port. Samples from the receive shift register enter a receive queue, and the CPU drains them through a read strobe. The CPU fills a transmit queue through a write strobe, and the transmit shift register pulls samples from it each time it needs a new word. Both queues show their fill state to the CPU as plain status pins: empty, full, a near-full or near-empty level, and a sticky error flag. The CPU clears an error flag by pulsing a write-one clear strobe.

A debug freeze request comes from the system clock domain. Two flops bring it into the audio clock domain, and the synchronized level then stops all movement. No sample enters the receive queue and no sample leaves the transmit queue. Queue pointers, levels and flags hold their values. A CPU read of the receive queue still shows the oldest sample without removing it, and a CPU write to the transmit queue is thrown away. This lets a debugger read the queues without disturbing them. When the request drops, normal movement resumes as soon as the synchronized level falls. No sample is repeated, and none is lost apart from those turned away during the freeze.

Both sample streams use valid/ready. On the receive side `rx_ready` is low only while frozen. When not frozen, a sample offered to a full queue is still accepted, dropped, and reported as an overrun. On the transmit side `tx_valid` is low only while frozen. When not frozen, a pull from an empty queue still completes: it carries zero and is reported as an underrun.

Top module: `audio_fifo_freeze`

## Requirements
- R1: When not frozen, every receive handshake (`rx_valid` and `rx_ready` high) on a queue that is not full stores the sample. Successive `cpu_rx_rd` strobes return the samples in arrival order on `cpu_rx_rdata`, which always shows the oldest stored entry.
- R2: When not frozen, a receive handshake while the receive queue holds 8 entries, with no CPU read in the same cycle, drops the sample and sets `rx_overrun` on the next edge. The flag stays set until cleared.
- R3: When not frozen, `tx_valid` is high. Each CPU write to a queue that is not full is stored, and successive transmit handshakes (`tx_valid` and `tx_ready` high) deliver the written samples in order on `tx_data`.
- R4: A transmit handshake on an empty transmit queue carries `tx_data` = 0 and sets `tx_underrun` on the next edge. The flag stays set until cleared.
- R5: Empty means 0 entries and full means 8 entries. `rx_almost_full` is high at 6 or more entries. `tx_almost_empty` is high at 2 or fewer entries.
- R6: `frozen` rises on the second rising audio clock edge after `freeze_req` rises, and falls on the second rising edge after `freeze_req` falls.
- R7: While `frozen` is high, `rx_ready` is low and no receive sample enters. `cpu_rx_rd` does not advance the queue: `cpu_rx_rdata` keeps showing the same entry. All four receive flags hold their values.
- R8: While `frozen` is high, `tx_valid` is low and no sample leaves the transmit queue. `cpu_tx_wr` is discarded. All four transmit flags hold their values.
- R9: `cpu_clr_overrun` and `cpu_clr_underrun` clear their sticky flags on the next edge only while not frozen. While frozen they have no effect.
- R10: After release, the next CPU reads return the receive samples that were stored before the freeze, in order, with nothing repeated. The next transmit pulls deliver the stored transmit samples the same way.
- R11: A CPU write to a full transmit queue (8 entries) is dropped without setting any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aud | input | 1 | Audio clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_aud |
| freeze_req | input | 1 | Debug freeze request from another clock domain |
| frozen | output | 1 | Synchronized freeze level |
| rx_valid | input | 1 | Receive shift register has a sample |
| rx_ready | output | 1 | Receive side accepts a sample |
| rx_data | input | 16 | Receive sample |
| cpu_rx_rd | input | 1 | CPU read strobe for the receive queue |
| cpu_rx_rdata | output | 16 | Oldest receive entry |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_almost_full | output | 1 | Receive level at 6 or more |
| rx_overrun | output | 1 | Sticky receive overrun |
| cpu_clr_overrun | input | 1 | Write-one clear of rx_overrun |
| cpu_tx_wr | input | 1 | CPU write strobe for the transmit queue |
| cpu_tx_wdata | input | 16 | Transmit sample from the CPU |
| tx_valid | output | 1 | Transmit side offers a sample |
| tx_ready | input | 1 | Transmit shift register loads a sample |
| tx_data | output | 16 | Transmit sample (zero when empty) |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_almost_empty | output | 1 | Transmit level at 2 or fewer |
| tx_underrun | output | 1 | Sticky transmit underrun |
| cpu_clr_underrun | input | 1 | Write-one clear of tx_underrun |

## Verification
The synchronizer assertion assumes `freeze_req` is low throughout reset and stays steady around each sampling edge. The bench meets this by driving the request only on falling edges and only after reset is released. The queue assertions assume strobes are single-cycle levels sampled on rising edges. The bench drives every strobe and every stream signal on falling edges and holds each one for a whole cycle.

// File: rtl/afz_pkg.sv
package afz_pkg;
  localparam int unsigned SAMPLE_W   = 16;
  localparam int unsigned QUEUE_DEPTH = 8;
  localparam int unsigned NEAR_FULL  = 6;
  localparam int unsigned NEAR_EMPTY = 2;

  typedef enum logic [0:0] {
    ERR_ON_OVERFLOW  = 1'b0,
    ERR_ON_UNDERFLOW = 1'b1
  } err_kind_e;
endpackage

// File: rtl/afz_sync.sv
module afz_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] since_rst;
      always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      end
      // R6: output follows the request two edges late
      p_sync_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (sync_out == $past(async_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/afz_queue.sv
module afz_queue
  import afz_pkg::*;
#(
  parameter int unsigned DATA_W = SAMPLE_W,
  parameter int unsigned DEPTH  = QUEUE_DEPTH,
  parameter int unsigned HI_LVL = NEAR_FULL,
  parameter int unsigned LO_LVL = NEAR_EMPTY,
  parameter err_kind_e   ERR_KIND = ERR_ON_OVERFLOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              err_clr,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full,
  output logic              near_full,
  output logic              near_empty,
  output logic              err_flag
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(HI_LVL);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(LO_LVL);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  level;
  logic              push_ok, pop_ok, err_evt, clr_ok;

  always_comb begin
    pop_ok  = pop_req  && !hold && (level != '0);
    push_ok = push_req && !hold && ((level != CNT_MAX) || pop_ok);
  end

  generate
    if (ERR_KIND == ERR_ON_OVERFLOW) begin : g_ovf
      assign err_evt = push_req && !hold && (level == CNT_MAX) && !pop_ok;
    end else begin : g_unf
      assign err_evt = pop_req && !hold && (level == '0);
    end
  endgenerate

  assign clr_ok = err_clr && !hold;

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      err_flag <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (err_evt)     err_flag <= 1'b1;
      else if (clr_ok) err_flag <= 1'b0;
    end
  end

  assign head_data  = store[rd_ptr];
  assign empty      = (level == '0);
  assign full       = (level == CNT_MAX);
  assign near_full  = (level >= CNT_HI);
  assign near_empty = (level <= CNT_LO);

  // R5: level never exceeds the depth
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_MAX);
  // R5: empty and full are exclusive
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R7 / R8: held queue keeps level and head
  p_hold_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(level) && $stable(rd_ptr)));
  // R9: sticky error holds unless an unfrozen clear arrives
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(err_clr && !hold)) |=> err_flag);
  // R9: error flag does not change while held
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(err_flag));
endmodule

// File: rtl/audio_fifo_freeze.sv
module audio_fifo_freeze
  import afz_pkg::*;
#(
  parameter int unsigned DATA_W      = SAMPLE_W,
  parameter int unsigned DEPTH       = QUEUE_DEPTH,
  parameter int unsigned RX_HI_LVL   = NEAR_FULL,
  parameter int unsigned TX_LO_LVL   = NEAR_EMPTY,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_aud,
  input  logic              rst_n,
  input  logic              freeze_req,
  output logic              frozen,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cpu_rx_rd,
  output logic [DATA_W-1:0] cpu_rx_rdata,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_almost_full,
  output logic              rx_overrun,
  input  logic              cpu_clr_overrun,
  input  logic              cpu_tx_wr,
  input  logic [DATA_W-1:0] cpu_tx_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_almost_empty,
  output logic              tx_underrun,
  input  logic              cpu_clr_underrun
);
  logic [DATA_W-1:0] tx_head;
  logic              rx_near_empty_unused, tx_near_full_unused;

  afz_sync #(.STAGES(SYNC_STAGES)) u_freeze_sync (
    .clk      (clk_aud),
    .rst_n    (rst_n),
    .async_in (freeze_req),
    .sync_out (frozen)
  );

  assign rx_ready = !frozen;
  assign tx_valid = !frozen;

  afz_queue #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .HI_LVL  (RX_HI_LVL),
    .LO_LVL  (TX_LO_LVL),
    .ERR_KIND(ERR_ON_OVERFLOW)
  ) u_rx_queue (
    .clk        (clk_aud),
    .rst_n      (rst_n),
    .hold       (frozen),
    .push_req   (rx_valid && rx_ready),
    .push_data  (rx_data),
    .pop_req    (cpu_rx_rd),
    .err_clr    (cpu_clr_overrun),
    .head_data  (cpu_rx_rdata),
    .empty      (rx_empty),
    .full       (rx_full),
    .near_full  (rx_almost_full),
    .near_empty (rx_near_empty_unused),
    .err_flag   (rx_overrun)
  );

  afz_queue #(
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .HI_LVL  (RX_HI_LVL),
    .LO_LVL  (TX_LO_LVL),
    .ERR_KIND(ERR_ON_UNDERFLOW)
  ) u_tx_queue (
    .clk        (clk_aud),
    .rst_n      (rst_n),
    .hold       (frozen),
    .push_req   (cpu_tx_wr),
    .push_data  (cpu_tx_wdata),
    .pop_req    (tx_valid && tx_ready),
    .err_clr    (cpu_clr_underrun),
    .head_data  (tx_head),
    .empty      (tx_empty),
    .full       (tx_full),
    .near_full  (tx_near_full_unused),
    .near_empty (tx_almost_empty),
    .err_flag   (tx_underrun)
  );

  assign tx_data = tx_empty ? '0 : tx_head;

  // R2: full receive queue offered a sample without a read raises overrun
  p_rx_drop_r2: assert property (@(posedge clk_aud) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_full && !cpu_rx_rd) |=> rx_overrun);
  // R4: pull from an empty transmit queue raises underrun
  p_tx_starve_r4: assert property (@(posedge clk_aud) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_empty) |=> tx_underrun);
  // R7: receive flags steady while frozen
  p_rx_flags_hold_r7: assert property (@(posedge clk_aud) disable iff (!rst_n)
    frozen |=> ($stable(rx_empty) && $stable(rx_full) && $stable(rx_almost_full)
                && $stable(cpu_rx_rdata)));
  // R8: transmit flags steady while frozen
  p_tx_flags_hold_r8: assert property (@(posedge clk_aud) disable iff (!rst_n)
    frozen |=> ($stable(tx_empty) && $stable(tx_full) && $stable(tx_almost_empty)));
endmodule

// File: tb/test_audio_fifo_freeze.sv
module test_audio_fifo_freeze;
  logic        clk_aud = 1'b0;
  logic        rst_n;
  logic        freeze_req, frozen;
  logic        rx_valid, rx_ready;
  logic [15:0] rx_data, cpu_rx_rdata;
  logic        cpu_rx_rd, rx_empty, rx_full, rx_almost_full, rx_overrun, cpu_clr_overrun;
  logic        cpu_tx_wr, tx_valid, tx_ready;
  logic [15:0] cpu_tx_wdata, tx_data;
  logic        tx_empty, tx_full, tx_almost_empty, tx_underrun, cpu_clr_underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_aud = ~clk_aud;  // 125 MHz

  audio_fifo_freeze i_audio_fifo_freeze (
    .clk_aud, .rst_n, .freeze_req, .frozen,
    .rx_valid, .rx_ready, .rx_data, .cpu_rx_rd, .cpu_rx_rdata,
    .rx_empty, .rx_full, .rx_almost_full, .rx_overrun, .cpu_clr_overrun,
    .cpu_tx_wr, .cpu_tx_wdata, .tx_valid, .tx_ready, .tx_data,
    .tx_empty, .tx_full, .tx_almost_empty, .tx_underrun, .cpu_clr_underrun
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_aud);
  endtask

  task automatic rx_push(input logic [15:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk_aud);
    rx_valid = 1'b0;
  endtask

  task automatic cpu_read(output logic [15:0] d);
    d = cpu_rx_rdata; cpu_rx_rd = 1'b1;
    @(negedge clk_aud);
    cpu_rx_rd = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] d);
    cpu_tx_wr = 1'b1; cpu_tx_wdata = d;
    @(negedge clk_aud);
    cpu_tx_wr = 1'b0;
  endtask

  task automatic tx_pull(output logic [15:0] d);
    d = tx_data; tx_ready = 1'b1;
    @(negedge clk_aud);
    tx_ready = 1'b0;
  endtask

  task automatic set_freeze(input logic v);
    freeze_req = v;
    @(negedge clk_aud);
    check("R6 frozen after one edge", frozen, !v);
    @(negedge clk_aud);
    check("R6 frozen after two edges", frozen, v);
  endtask

  task automatic t_reset;
    check("R5 reset rx_empty", rx_empty, 1);
    check("R5 reset tx_empty", tx_empty, 1);
    check("R5 reset tx_almost_empty", tx_almost_empty, 1);
    check("R2 reset overrun", rx_overrun, 0);
    check("R4 reset underrun", tx_underrun, 0);
    check("R1 reset rx_ready", rx_ready, 1);
    check("R3 reset tx_valid", tx_valid, 1);
  endtask

  task automatic t_rx_fill_overrun;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      rx_push(16'h1000 + 16'(i));
      check("R5 rx_almost_full level", rx_almost_full, (i + 1) >= 6);
      check("R5 rx_full level", rx_full, (i + 1) == 8);
    end
    check("R2 no overrun yet", rx_overrun, 0);
    rx_push(16'hDEAD);
    check("R2 overrun set", rx_overrun, 1);
    for (int i = 0; i < 8; i++) begin
      cpu_read(d);
      check("R1 rx order", d, 16'h1000 + 16'(i));
    end
    check("R1 rx empty after drain", rx_empty, 1);
    check("R2 overrun sticky", rx_overrun, 1);
    cpu_clr_overrun = 1'b1; @(negedge clk_aud); cpu_clr_overrun = 1'b0;
    check("R9 overrun cleared", rx_overrun, 0);
  endtask

  task automatic t_tx_order_full;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      cpu_write(16'h2000 + 16'(i));
      check("R5 tx_almost_empty level", tx_almost_empty, (i + 1) <= 2);
    end
    check("R5 tx_full", tx_full, 1);
    cpu_write(16'hBEEF);
    check("R11 no flag on full write", tx_underrun, 0);
    for (int i = 0; i < 8; i++) begin
      tx_pull(d);
      check("R3 tx order", d, 16'h2000 + 16'(i));
    end
    check("R11 full write dropped", tx_empty, 1);
    tx_pull(d);
    check("R4 zero on empty", d, 0);
    check("R4 underrun set", tx_underrun, 1);
  endtask

  task automatic t_rx_freeze;
    logic [15:0] d;
    rx_push(16'hA001); rx_push(16'hA002); rx_push(16'hA003);
    set_freeze(1'b1);
    check("R7 rx_ready low", rx_ready, 0);
    rx_push(16'hFFFF);
    cpu_read(d);
    check("R7 read while frozen", d, 16'hA001);
    cpu_read(d);
    check("R7 read does not advance", d, 16'hA001);
    check("R7 rx_empty held", rx_empty, 0);
    check("R7 rx_almost_full held", rx_almost_full, 0);
    set_freeze(1'b0);
    for (int i = 1; i <= 3; i++) begin
      cpu_read(d);
      check("R10 rx resume order", d, 16'hA000 + 16'(i));
    end
    check("R7 frozen sample not stored", rx_empty, 1);
  endtask

  task automatic t_tx_freeze;
    logic [15:0] d;
    cpu_write(16'hB001); cpu_write(16'hB002);
    check("R8 underrun still set", tx_underrun, 1);
    set_freeze(1'b1);
    check("R8 tx_valid low", tx_valid, 0);
    cpu_write(16'hCCCC);
    tx_pull(d);
    check("R8 tx_almost_empty held", tx_almost_empty, 1);
    check("R8 tx_empty held", tx_empty, 0);
    cpu_clr_underrun = 1'b1; @(negedge clk_aud); cpu_clr_underrun = 1'b0;
    check("R9 clear ignored while frozen", tx_underrun, 1);
    set_freeze(1'b0);
    tx_pull(d); check("R10 tx resume first", d, 16'hB001);
    tx_pull(d); check("R10 tx resume second", d, 16'hB002);
    check("R8 frozen write discarded", tx_empty, 1);
    cpu_clr_underrun = 1'b1; @(negedge clk_aud); cpu_clr_underrun = 1'b0;
    check("R9 underrun cleared", tx_underrun, 0);
  endtask

  initial begin
    rst_n = 1'b0; freeze_req = 1'b0;
    rx_valid = 1'b0; rx_data = '0; cpu_rx_rd = 1'b0; cpu_clr_overrun = 1'b0;
    cpu_tx_wr = 1'b0; cpu_tx_wdata = '0; tx_ready = 1'b0; cpu_clr_underrun = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_rx_fill_overrun();
    t_tx_order_full();
    t_rx_freeze();
    t_tx_freeze();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk_aud);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule